// File: doc/BRIEF.md
# Early-Request Issue Gate with Bank-Busy Check

This block sits between a CPU's cache controller and a shared address bus on which memory is split into sixteen banks. When the cache starts a tag probe it also hands the block the address and command. The block raises a bus request at once, so that arbitration runs while the tag lookup is still in progress. It latches the address, decodes the target bank from fixed address bits, and tracks which banks are busy by watching bank-busy set and release events from the bus.

When the arbiter grants the bus, the block puts the address, command and bank number on the bus for exactly one cycle, but only if the target bank is free. If the bank is busy, it lets the grant go, drops its request for one cycle and then asks again. If the tag lookup reports a hit before the request has been issued, the request is withdrawn and nothing reaches the bus. After an issue, a one-cycle done pulse goes back to the cache side. Only one request is handled at a time.

Top module: `erq_issue_gate`

## Requirements
- R1: After reset, `bus_req_o`, `bus_vld_o` and `done_o` are low, `probe_rdy_o` is high, and every bank is treated as free.
- R2: A probe accepted while `probe_rdy_o` is high raises `bus_req_o` in the next cycle, whether or not a tag result has arrived.
- R3: The bank number driven on the bus is address bits [BANK_LSB+3:BANK_LSB] (bits 9:6 by default) of the latched probe address. It is sent together with that address and the probe's command.
- R4: A grant sampled while requesting, with the target bank free and no hit in that cycle, makes `bus_vld_o` high for exactly the next cycle. While `bus_vld_o` is low, the bus address, command and bank outputs are zero.
- R5: `done_o` pulses high for one cycle, in the cycle right after the bus drive cycle.
- R6: A tag hit (`tag_done_i` and `tag_hit_i`) sampled while requesting, including in the same cycle as a grant, drops the request in the next cycle. No bus drive and no done pulse follow, and `probe_rdy_o` returns high.
- R7: A grant sampled while the target bank is busy causes no drive. `bus_req_o` is low for one cycle and then high again.
- R8: A tag miss leaves the request pending. A tag result that arrives after the grant has no effect on the drive or on the done pulse.
- R9: A bank becomes busy on `busy_set_vld_i` for its number and free on `busy_clr_vld_i` for its number. When both events name the same bank in one cycle, the bank ends up busy.
- R10: `probe_rdy_o` is low from the accepted probe until the cycle after the issue or cancel. A probe offered meanwhile is ignored, and the latched address and command stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_vld_i | input | 1 | Tag probe start strobe with request |
| probe_addr_i | input | ADDR_W | Request address |
| probe_cmd_i | input | CMD_W | Request command |
| probe_rdy_o | output | 1 | Block can accept a new probe |
| tag_done_i | input | 1 | Tag lookup result valid |
| tag_hit_i | input | 1 | Tag lookup hit (with tag_done_i) |
| bus_req_o | output | 1 | Address bus request to arbiter |
| bus_gnt_i | input | 1 | Address bus grant |
| busy_set_vld_i | input | 1 | Bus reports a bank became busy |
| busy_set_bank_i | input | BANK_W | Bank that became busy |
| busy_clr_vld_i | input | 1 | Bus reports a bank became free |
| busy_clr_bank_i | input | BANK_W | Bank that became free |
| bus_vld_o | output | 1 | Address cycle valid on bus |
| bus_addr_o | output | ADDR_W | Address driven on bus |
| bus_cmd_o | output | CMD_W | Command driven on bus |
| bus_bank_o | output | BANK_W | Bank number driven on bus |
| done_o | output | 1 | Request issued, to cache side |

## Verification
The bench puts a tag hit in the same cycle as a grant. A design that lets the grant win would drive a request the cache already satisfied. It grants while the target bank is busy and expects the request to drop and come back one cycle later. A design that ignores the busy state would drive into a busy bank, and one that keeps its request high would never free the arbiter. It sets and releases the same bank in one cycle, where the wrong priority issues too early. It offers a second probe while one is pending, where a design that reloads its registers drives the wrong address.

// File: rtl/erq_pkg.sv
package erq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_DRIVE   = 2'd3
  } erq_state_e;

endpackage

// File: rtl/erq_bank_tracker.sv
module erq_bank_tracker #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld_i,
  input  logic [BANK_W-1:0] set_bank_i,
  input  logic              clr_vld_i,
  input  logic [BANK_W-1:0] clr_bank_i,
  input  logic [BANK_W-1:0] query_bank_i,
  output logic              query_busy_o
);

  localparam int NUM_BANKS = 1 << BANK_W;

  logic [NUM_BANKS-1:0] busy_q;

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    logic set_hit;
    logic clr_hit;
    logic busy_d;
    logic upd_en;

    assign set_hit = set_vld_i && (set_bank_i == BANK_W'(gi));
    assign clr_hit = clr_vld_i && (clr_bank_i == BANK_W'(gi));
    assign upd_en  = set_hit || clr_hit;
    // a new address cycle to the bank outranks a release in the same cycle
    assign busy_d  = set_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[gi] <= 1'b0;
      end else if (upd_en) begin
        busy_q[gi] <= busy_d;
      end
    end
  end

  assign query_busy_o = busy_q[query_bank_i];

endmodule

// File: rtl/erq_issue_fsm.sv
module erq_issue_fsm
  import erq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic probe_vld_i,
  input  logic tag_done_i,
  input  logic tag_hit_i,
  input  logic bus_gnt_i,
  input  logic bank_busy_i,
  output logic load_en_o,
  output logic bus_req_o,
  output logic drive_o,
  output logic done_o,
  output logic probe_rdy_o
);

  erq_state_e state_q;
  erq_state_e state_d;
  logic       done_q;
  logic       hit_now;

  assign hit_now = tag_done_i && tag_hit_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (probe_vld_i) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (hit_now) begin
          state_d = ST_IDLE;
        end else if (bus_gnt_i) begin
          state_d = bank_busy_i ? ST_BACKOFF : ST_DRIVE;
        end
      end
      ST_BACKOFF: begin
        state_d = hit_now ? ST_IDLE : ST_REQ;
      end
      ST_DRIVE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DRIVE);
    end
  end

  assign probe_rdy_o = (state_q == ST_IDLE);
  assign load_en_o   = probe_rdy_o && probe_vld_i;
  assign bus_req_o   = (state_q == ST_REQ);
  assign drive_o     = (state_q == ST_DRIVE);
  assign done_o      = done_q;

endmodule

// File: rtl/erq_issue_gate.sv
module erq_issue_gate #(
  parameter int ADDR_W   = 32,
  parameter int CMD_W    = 4,
  parameter int BANK_W   = 4,
  parameter int BANK_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_vld_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  input  logic [CMD_W-1:0]  probe_cmd_i,
  output logic              probe_rdy_o,
  input  logic              tag_done_i,
  input  logic              tag_hit_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic              busy_set_vld_i,
  input  logic [BANK_W-1:0] busy_set_bank_i,
  input  logic              busy_clr_vld_i,
  input  logic [BANK_W-1:0] busy_clr_bank_i,
  output logic              bus_vld_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [CMD_W-1:0]  bus_cmd_o,
  output logic [BANK_W-1:0] bus_bank_o,
  output logic              done_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [BANK_W-1:0] bank_dec;
  logic              load_en;
  logic              drive;
  logic              bank_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (load_en) begin
      addr_q <= probe_addr_i;
      cmd_q  <= probe_cmd_i;
    end
  end

  assign bank_dec = addr_q[BANK_LSB +: BANK_W];

  erq_bank_tracker #(
    .BANK_W (BANK_W)
  ) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_vld_i    (busy_set_vld_i),
    .set_bank_i   (busy_set_bank_i),
    .clr_vld_i    (busy_clr_vld_i),
    .clr_bank_i   (busy_clr_bank_i),
    .query_bank_i (bank_dec),
    .query_busy_o (bank_busy)
  );

  erq_issue_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_vld_i (probe_vld_i),
    .tag_done_i  (tag_done_i),
    .tag_hit_i   (tag_hit_i),
    .bus_gnt_i   (bus_gnt_i),
    .bank_busy_i (bank_busy),
    .load_en_o   (load_en),
    .bus_req_o   (bus_req_o),
    .drive_o     (drive),
    .done_o      (done_o),
    .probe_rdy_o (probe_rdy_o)
  );

  assign bus_vld_o  = drive;
  assign bus_addr_o = drive ? addr_q   : '0;
  assign bus_cmd_o  = drive ? cmd_q    : '0;
  assign bus_bank_o = drive ? bank_dec : '0;

endmodule

// File: rtl/erq_issue_gate_chk.sv
module erq_issue_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              probe_vld_i,
  input logic              probe_rdy_o,
  input logic              tag_done_i,
  input logic              tag_hit_i,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_vld_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [CMD_W-1:0]  bus_cmd_o,
  input logic [BANK_W-1:0] bus_bank_o,
  input logic              done_o
);

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld_o |=> !bus_vld_o); // R4

  AST_VLD_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_vld_o) |-> ($past(bus_gnt_i) && $past(bus_req_o))); // R4

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld_o |-> (bus_addr_o == '0 && bus_cmd_o == '0 && bus_bank_o == '0)); // R4

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_vld_o)); // R5

  AST_REQ_ON_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_rdy_o && probe_vld_i) |=> bus_req_o); // R2

  AST_HIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && tag_done_i && tag_hit_i) |=> (!bus_req_o && !bus_vld_o && probe_rdy_o)); // R6

  AST_BUSY_NOT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o || bus_vld_o) |-> !probe_rdy_o); // R10

endmodule

bind erq_issue_gate erq_issue_gate_chk #(
  .ADDR_W (ADDR_W),
  .CMD_W  (CMD_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .probe_vld_i (probe_vld_i),
  .probe_rdy_o (probe_rdy_o),
  .tag_done_i  (tag_done_i),
  .tag_hit_i   (tag_hit_i),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_vld_o   (bus_vld_o),
  .bus_addr_o  (bus_addr_o),
  .bus_cmd_o   (bus_cmd_o),
  .bus_bank_o  (bus_bank_o),
  .done_o      (done_o)
);

// File: tb/test_erq_issue_gate.sv
`timescale 1ns/1ps
module test_erq_issue_gate;

  localparam int ADDR_W   = 32;
  localparam int CMD_W    = 4;
  localparam int BANK_W   = 4;
  localparam int BANK_LSB = 6;

  logic              clk;
  logic              rst_n;
  logic              probe_vld_i;
  logic [ADDR_W-1:0] probe_addr_i;
  logic [CMD_W-1:0]  probe_cmd_i;
  logic              probe_rdy_o;
  logic              tag_done_i;
  logic              tag_hit_i;
  logic              bus_req_o;
  logic              bus_gnt_i;
  logic              busy_set_vld_i;
  logic [BANK_W-1:0] busy_set_bank_i;
  logic              busy_clr_vld_i;
  logic [BANK_W-1:0] busy_clr_bank_i;
  logic              bus_vld_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [CMD_W-1:0]  bus_cmd_o;
  logic [BANK_W-1:0] bus_bank_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  erq_issue_gate #(
    .ADDR_W (ADDR_W), .CMD_W (CMD_W), .BANK_W (BANK_W), .BANK_LSB (BANK_LSB)
  ) i_erq_issue_gate (
    .clk (clk), .rst_n (rst_n),
    .probe_vld_i (probe_vld_i), .probe_addr_i (probe_addr_i), .probe_cmd_i (probe_cmd_i),
    .probe_rdy_o (probe_rdy_o), .tag_done_i (tag_done_i), .tag_hit_i (tag_hit_i),
    .bus_req_o (bus_req_o), .bus_gnt_i (bus_gnt_i),
    .busy_set_vld_i (busy_set_vld_i), .busy_set_bank_i (busy_set_bank_i),
    .busy_clr_vld_i (busy_clr_vld_i), .busy_clr_bank_i (busy_clr_bank_i),
    .bus_vld_o (bus_vld_o), .bus_addr_o (bus_addr_o), .bus_cmd_o (bus_cmd_o),
    .bus_bank_o (bus_bank_o), .done_o (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[BANK_LSB +: BANK_W];
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    probe_vld_i = 0; tag_done_i = 0; tag_hit_i = 0; bus_gnt_i = 0;
    busy_set_vld_i = 0; busy_clr_vld_i = 0;
  endtask

  task automatic probe(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c);
    probe_vld_i = 1; probe_addr_i = a; probe_cmd_i = c;
    tick();
    probe_vld_i = 0;
  endtask

  task automatic expect_issue(input string req, input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c);
    chk(req, "vld", 64'(bus_vld_o), 64'd1);
    chk("R3", "addr", 64'(bus_addr_o), 64'(a));
    chk("R3", "cmd", 64'(bus_cmd_o), 64'(c));
    chk("R3", "bank", 64'(bus_bank_o), 64'(bank_of(a)));
    chk(req, "req low in drive", 64'(bus_req_o), 64'd0);
    tick();
    chk("R4", "vld one cycle", 64'(bus_vld_o), 64'd0);
    chk("R4", "addr zero", 64'(bus_addr_o), 64'd0);
    chk("R5", "done", 64'(done_o), 64'd1);
    chk("R10", "rdy back", 64'(probe_rdy_o), 64'd1);
    tick();
    chk("R5", "done one cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "req", 64'(bus_req_o), 64'd0);
    chk("R1", "vld", 64'(bus_vld_o), 64'd0);
    chk("R1", "done", 64'(done_o), 64'd0);
    chk("R1", "rdy", 64'(probe_rdy_o), 64'd1);
  endtask

  task automatic t_basic();
    logic [ADDR_W-1:0] a = 32'h1234_5A40;
    probe(a, 4'h3);
    chk("R2", "req early", 64'(bus_req_o), 64'd1);
    chk("R10", "rdy low", 64'(probe_rdy_o), 64'd0);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    expect_issue("R4", a, 4'h3);
  endtask

  task automatic t_miss_then_late_gnt();
    logic [ADDR_W-1:0] a = 32'h0000_03C0;
    probe(a, 4'hA);
    tag_done_i = 1; tag_hit_i = 0;
    tick();
    tag_done_i = 0;
    chk("R8", "req after miss", 64'(bus_req_o), 64'd1);
    tick(); tick();
    chk("R8", "still requesting", 64'(bus_req_o), 64'd1);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    tag_done_i = 1; tag_hit_i = 1;
    chk("R8", "vld", 64'(bus_vld_o), 64'd1);
    tick();
    tag_done_i = 0; tag_hit_i = 0;
    chk("R8", "done despite late hit", 64'(done_o), 64'd1);
    tick();
  endtask

  task automatic t_hit_before_gnt();
    probe(32'h0000_0100, 4'h1);
    tag_done_i = 1; tag_hit_i = 1;
    tick();
    tag_done_i = 0; tag_hit_i = 0;
    chk("R6", "req dropped", 64'(bus_req_o), 64'd0);
    chk("R6", "rdy back", 64'(probe_rdy_o), 64'd1);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    chk("R6", "no vld", 64'(bus_vld_o), 64'd0);
    tick();
    chk("R6", "no done", 64'(done_o), 64'd0);
  endtask

  task automatic t_hit_with_gnt();
    probe(32'h0000_0280, 4'h2);
    tag_done_i = 1; tag_hit_i = 1; bus_gnt_i = 1;
    tick();
    idle_inputs();
    chk("R6", "no vld on hit+gnt", 64'(bus_vld_o), 64'd0);
    chk("R6", "req dropped", 64'(bus_req_o), 64'd0);
    tick();
    chk("R6", "no done on hit+gnt", 64'(done_o), 64'd0);
  endtask

  task automatic t_busy_bank();
    logic [ADDR_W-1:0] a = 32'hABC0_0140;
    busy_set_vld_i = 1; busy_set_bank_i = 4'd5;
    tick();
    busy_set_vld_i = 0;
    probe(a, 4'h7);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    chk("R7", "no vld when busy", 64'(bus_vld_o), 64'd0);
    chk("R7", "req backs off", 64'(bus_req_o), 64'd0);
    chk("R10", "rdy low in backoff", 64'(probe_rdy_o), 64'd0);
    tick();
    chk("R7", "req again", 64'(bus_req_o), 64'd1);
    busy_clr_vld_i = 1; busy_clr_bank_i = 4'd5;
    tick();
    busy_clr_vld_i = 0;
    chk("R9", "still requesting", 64'(bus_req_o), 64'd1);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    expect_issue("R9", a, 4'h7);
  endtask

  task automatic t_set_clr_same();
    logic [ADDR_W-1:0] a = 32'h0000_00C0;
    busy_set_vld_i = 1; busy_set_bank_i = 4'd3;
    busy_clr_vld_i = 1; busy_clr_bank_i = 4'd3;
    tick();
    busy_set_vld_i = 0; busy_clr_vld_i = 0;
    probe(a, 4'h9);
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    chk("R9", "set wins over clear", 64'(bus_vld_o), 64'd0);
    tick();
    busy_clr_vld_i = 1; busy_clr_bank_i = 4'd3;
    tick();
    busy_clr_vld_i = 0;
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    expect_issue("R9", a, 4'h9);
  endtask

  task automatic t_probe_ignored();
    logic [ADDR_W-1:0] a = 32'h0F00_0380;
    probe(a, 4'h4);
    probe_vld_i = 1; probe_addr_i = 32'h7777_7FC0; probe_cmd_i = 4'hF;
    tick();
    probe_vld_i = 0;
    bus_gnt_i = 1;
    tick();
    bus_gnt_i = 0;
    chk("R10", "first addr kept", 64'(bus_addr_o), 64'(a));
    chk("R10", "first cmd kept", 64'(bus_cmd_o), 64'h4);
    tick(); tick();
  endtask

  initial begin
    idle_inputs();
    probe_addr_i = '0; probe_cmd_i = '0;
    busy_set_bank_i = '0; busy_clr_bank_i = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_miss_then_late_gnt();
    t_hit_before_gnt();
    t_hit_with_gnt();
    t_busy_bank();
    t_set_clr_same();
    t_probe_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule